// File: doc/BRIEF.md
# Dual-Slot Bus Frequency Arbiter

This block merges the bus-frequency settings reported by two processor sockets into one common bus-frequency code. Each socket reports a 3-bit frequency code and a flag that says whether the socket is populated. If both sockets are populated, the slower of the two settings wins. If only one is populated, that socket's setting is used and the other socket's code is ignored.

A reference-valid input gates the result. While it is low, the block holds a fixed power-up default code that stands for 100 MHz. Once it rises, the output takes the computed selection. From then on the output follows every change on the codes and the occupancy flags.

All inputs arrive asynchronously. Each one passes through a two-flop synchroniser before the registered output stage. The ordering of codes by frequency comes from a rank table parameter, which by default is the unsigned value of the code.

Top module: `bus_freq_arbiter`

## Requirements
- R1: While rst_ni is low, freq_o equals DEFAULT_CODE (3'b000 by default) and valid_o is 0.
- R2: While the synchronised ref_ok_i is low, freq_o equals DEFAULT_CODE and valid_o is 0, whatever the codes and flags are.
- R3: With ref_ok_i high and both occ_a_i and occ_b_i high, freq_o is whichever of code_a_i and code_b_i has the lower rank. Under the default map, rank is the unsigned code value, so the smaller code is chosen.
- R4: With ref_ok_i high and exactly one occupancy flag high, freq_o equals that socket's code, whatever the other socket's code is.
- R5: With ref_ok_i high and neither occupancy flag high, freq_o equals DEFAULT_CODE and valid_o is 0.
- R6: valid_o is 1 exactly when the synchronised ref_ok_i is high and at least one occupancy flag is high.
- R7: An input value that is sampled at one rising clock edge appears on freq_o and valid_o after the third rising edge, counting that edge. Before then the outputs keep their previous value.
- R8: When ref_ok_i falls back low, the outputs return to DEFAULT_CODE with valid_o 0. When ref_ok_i rises again, the computed selection is restored.
- R9: While ref_ok_i stays high, any change of a code or an occupancy flag is reflected on the outputs with the R7 latency. No new reference event is needed.
- R10: When both sockets are populated and report equal codes, freq_o equals that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_a_i | input | 3 | Frequency code reported by socket A |
| code_b_i | input | 3 | Frequency code reported by socket B |
| occ_a_i | input | 1 | Socket A populated |
| occ_b_i | input | 1 | Socket B populated |
| ref_ok_i | input | 1 | Reference-valid qualifier |
| freq_o | output | 3 | Common bus-frequency code |
| valid_o | output | 1 | Output carries a computed selection |

## Verification
The hardest situation to reach from the ports is a drop of the reference qualifier in the middle of tracking, while a code change is still inside the synchroniser pipeline. The outputs must return to the default and must not expose the change that is in flight. The stimulus reaches this state in two ways. First, it toggles ref_ok_i randomly while the codes and flags also change, and compares the outputs against a model that is delayed by three cycles on every cycle. Second, it uses directed sequences that step the inputs one edge at a time to pin down the latency.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  parameter int unsigned CODE_W = 3;
  localparam int unsigned NCODES = 1 << CODE_W;
  localparam int unsigned MAP_W  = NCODES * CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  // rank table where rank equals the code value
  function automatic logic [MAP_W-1:0] identity_rank();
    logic [MAP_W-1:0] m;
    m = '0;
    for (int k = 0; k < NCODES; k++) m[k*CODE_W +: CODE_W] = CODE_W'(k);
    return m;
  endfunction
endpackage

// File: rtl/bfa_sync.sv
module bfa_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bfa_rank.sv
module bfa_rank
  import bfa_pkg::*;
#(
  parameter logic [MAP_W-1:0] RANK_MAP = identity_rank()
) (
  input  code_t code_i,
  output code_t rank_o
);
  assign rank_o = RANK_MAP[code_i*CODE_W +: CODE_W];
endmodule

// File: rtl/bfa_select.sv
module bfa_select
  import bfa_pkg::*;
#(
  parameter code_t DEFAULT_CODE = '0
) (
  input  code_t code_a_i,
  input  code_t code_b_i,
  input  code_t rank_a_i,
  input  code_t rank_b_i,
  input  logic  occ_a_i,
  input  logic  occ_b_i,
  input  logic  ref_ok_i,
  output code_t sel_o,
  output logic  sel_vld_o
);
  always_comb begin
    sel_o     = DEFAULT_CODE;
    sel_vld_o = 1'b0;
    if (ref_ok_i) begin
      unique case ({occ_a_i, occ_b_i})
        2'b11: begin
          sel_o     = (rank_b_i < rank_a_i) ? code_b_i : code_a_i;
          sel_vld_o = 1'b1;
        end
        2'b10: begin
          sel_o     = code_a_i;
          sel_vld_o = 1'b1;
        end
        2'b01: begin
          sel_o     = code_b_i;
          sel_vld_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bus_freq_arbiter.sv
module bus_freq_arbiter
  import bfa_pkg::*;
#(
  parameter code_t             DEFAULT_CODE = '0,
  parameter logic [MAP_W-1:0]  RANK_MAP     = identity_rank(),
  parameter int unsigned       SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic              occ_a_i,
  input  logic              occ_b_i,
  input  logic              ref_ok_i,
  output logic [CODE_W-1:0] freq_o,
  output logic              valid_o
);
  localparam int unsigned NSLOT = 2;
  localparam int unsigned SW    = NSLOT * (CODE_W + 1) + 1;

  logic [SW-1:0] raw, syn;
  code_t         code_s [NSLOT];
  code_t         rank_s [NSLOT];
  logic          occ_s  [NSLOT];
  logic          ref_s;
  code_t         sel;
  logic          sel_vld;

  assign raw = {ref_ok_i, occ_b_i, occ_a_i, code_b_i, code_a_i};

  bfa_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign ref_s = syn[SW-1];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign code_s[i] = syn[i*CODE_W +: CODE_W];
    assign occ_s[i]  = syn[NSLOT*CODE_W + i];

    bfa_rank #(.RANK_MAP(RANK_MAP)) u_rank (
      .code_i(code_s[i]),
      .rank_o(rank_s[i])
    );
  end

  bfa_select #(.DEFAULT_CODE(DEFAULT_CODE)) u_sel (
    .code_a_i (code_s[0]),
    .code_b_i (code_s[1]),
    .rank_a_i (rank_s[0]),
    .rank_b_i (rank_s[1]),
    .occ_a_i  (occ_s[0]),
    .occ_b_i  (occ_s[1]),
    .ref_ok_i (ref_s),
    .sel_o    (sel),
    .sel_vld_o(sel_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o  <= DEFAULT_CODE;
      valid_o <= 1'b0;
    end else begin
      freq_o  <= sel;
      valid_o <= sel_vld;
    end
  end
endmodule

// File: rtl/bus_freq_arbiter_chk.sv
module bus_freq_arbiter_chk
  import bfa_pkg::*;
#(
  parameter code_t DEFAULT_CODE = '0
) (
  input logic  clk_i,
  input logic  rst_ni,
  input code_t code_a_i,
  input code_t code_b_i,
  input logic  occ_a_i,
  input logic  occ_b_i,
  input logic  ref_ok_i,
  input code_t freq_o,
  input logic  valid_o
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  a_r1_reset_default: assert property (@(posedge clk_i)
    !rst_ni |-> (freq_o == DEFAULT_CODE && !valid_o));

  a_r2_ref_low_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(ref_ok_i, 3)) |-> (freq_o == DEFAULT_CODE && !valid_o));

  a_r3_both_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ref_ok_i && occ_a_i && occ_b_i, 3)) |->
      (freq_o == $past(code_a_i, 3) || freq_o == $past(code_b_i, 3)));

  a_r4_single_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ref_ok_i && occ_a_i && !occ_b_i, 3)) |-> (freq_o == $past(code_a_i, 3)));

  a_r4_single_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ref_ok_i && !occ_a_i && occ_b_i, 3)) |-> (freq_o == $past(code_b_i, 3)));

  a_r5_empty_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(!occ_a_i && !occ_b_i, 3)) |-> (freq_o == DEFAULT_CODE && !valid_o));

  a_r6_valid_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(ref_ok_i && (occ_a_i || occ_b_i), 3)));
endmodule

bind bus_freq_arbiter bus_freq_arbiter_chk #(.DEFAULT_CODE(DEFAULT_CODE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .code_a_i(code_a_i),
  .code_b_i(code_b_i),
  .occ_a_i (occ_a_i),
  .occ_b_i (occ_b_i),
  .ref_ok_i(ref_ok_i),
  .freq_o  (freq_o),
  .valid_o (valid_o)
);

// File: tb/bus_freq_arbiter_tb.sv
module bus_freq_arbiter_tb;
  localparam logic [2:0] DEF = 3'b000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] code_a_i = '0, code_b_i = '0;
  logic       occ_a_i = 1'b0, occ_b_i = 1'b0, ref_ok_i = 1'b0;
  logic [2:0] freq_o;
  logic       valid_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  bus_freq_arbiter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .code_a_i(code_a_i), .code_b_i(code_b_i),
    .occ_a_i(occ_a_i), .occ_b_i(occ_b_i), .ref_ok_i(ref_ok_i),
    .freq_o(freq_o), .valid_o(valid_o)
  );

  function automatic logic [3:0] model(logic [2:0] a, logic [2:0] b,
                                       logic oa, logic ob, logic r);
    if (!r || !(oa || ob)) return {1'b0, DEF};
    if (oa && ob)          return {1'b1, (b < a) ? b : a};
    if (oa)                return {1'b1, a};
    return {1'b1, b};
  endfunction

  task automatic check(string req, logic [3:0] exp);
    n_chk++;
    if ({valid_o, freq_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: valid/freq got %b/%b expected %b/%b",
               req, valid_o, freq_o, exp[3], exp[2:0]);
    end
  endtask

  task automatic drive(logic [2:0] a, logic [2:0] b, logic oa, logic ob, logic r);
    code_a_i = a; code_b_i = b; occ_a_i = oa; occ_b_i = ob; ref_ok_i = r;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    drive(3'd5, 3'd6, 1'b1, 1'b1, 1'b1);
    repeat (4) @(negedge clk_i);
    check("R1", {1'b0, DEF});
    drive(3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    settle();
    check("R1", {1'b0, DEF});
  endtask

  task automatic t_ref_low();
    for (int a = 0; a < 8; a += 3) begin
      drive(3'(a), 3'(7 - a), 1'b1, 1'b1, 1'b0);
      settle();
      check("R2", {1'b0, DEF});
    end
  endtask

  task automatic t_both();
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        drive(3'(a), 3'(b), 1'b1, 1'b1, 1'b1);
        settle();
        check(a == b ? "R10" : "R3", {1'b1, 3'((b < a) ? b : a)});
      end
  endtask

  task automatic t_single();
    for (int b = 0; b < 8; b++) begin
      drive(3'd6, 3'(b), 1'b1, 1'b0, 1'b1);
      settle();
      check("R4", {1'b1, 3'd6});
      drive(3'(b), 3'd5, 1'b0, 1'b1, 1'b1);
      settle();
      check("R4", {1'b1, 3'd5});
    end
  endtask

  task automatic t_none();
    drive(3'd4, 3'd2, 1'b0, 1'b0, 1'b1);
    settle();
    check("R5", {1'b0, DEF});
    check("R6", {1'b0, DEF});
  endtask

  task automatic t_latency();
    drive(3'd3, 3'd3, 1'b1, 1'b0, 1'b1);
    settle();
    drive(3'd1, 3'd7, 1'b1, 1'b1, 1'b1);
    repeat (2) @(negedge clk_i);
    check("R7", {1'b1, 3'd3});
    @(negedge clk_i);
    check("R7", {1'b1, 3'd1});
  endtask

  task automatic t_ref_toggle();
    drive(3'd4, 3'd2, 1'b1, 1'b1, 1'b1);
    settle();
    check("R8", {1'b1, 3'd2});
    ref_ok_i = 1'b0;
    settle();
    check("R8", {1'b0, DEF});
    ref_ok_i = 1'b1;
    settle();
    check("R8", {1'b1, 3'd2});
  endtask

  task automatic t_tracking();
    drive(3'd5, 3'd6, 1'b1, 1'b1, 1'b1);
    settle();
    check("R9", {1'b1, 3'd5});
    occ_a_i = 1'b0;
    settle();
    check("R9", {1'b1, 3'd6});
    code_b_i = 3'd1;
    settle();
    check("R9", {1'b1, 3'd1});
  endtask

  // per-cycle compare against a 3-deep model pipeline with random ref toggling
  task automatic t_random();
    logic [3:0] pipe [3];
    for (int k = 0; k < 3; k++) pipe[k] = model(code_a_i, code_b_i, occ_a_i, occ_b_i, ref_ok_i);
    for (int n = 0; n < 400; n++) begin
      drive(3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 4) != 0);
      pipe[2] = pipe[1]; pipe[1] = pipe[0];
      pipe[0] = model(code_a_i, code_b_i, occ_a_i, occ_b_i, ref_ok_i);
      @(negedge clk_i);
      if (n >= 3) check("R6/R8 random", pipe[2]);
    end
  endtask

  initial begin
    t_reset();
    t_ref_low();
    t_both();
    t_single();
    t_none();
    t_latency();
    t_ref_toggle();
    t_tracking();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule